// File: doc/BRIEF.md
# Cartridge Bank Register Decoder

This block sits between a CPU bus and the memories of a game cartridge. It watches CPU writes in the upper half of the address space and keeps a small set of control registers. It holds a switchable program bank, four character bank numbers, a nametable mirroring mode and a work-RAM write enable. From those registers it translates addresses. The program half gets a switchable 16 KiB window at 0x8000 and a 16 KiB window at 0xC000 that is tied to the last installed bank. The character side gets four 2 KiB slots, each picked by the two upper bits of the picture-side address. Write strobes to 0x6000–0x7FFF are gated by the enable bit.

The block also answers three CPU reads in the expansion area. One of them is a status byte that carries a DIP switch. For any other address it reports that it does not drive the bus. That lets the caller keep the previous bus value.

Every port is a plain control or status pin. A CPU access lasts one cycle, with no valid/ready pairing and no back-pressure. A register write takes effect at the clock edge that ends the strobe cycle. Address translation and read data are combinational from the current address and the stored registers.

Top module: `cart_bank_decoder`

## Requirements
- R1: After reset the program bank and all four character banks are 0, the mirroring code is 0 (vertical) and work-RAM writes are blocked.
- R2: A write whose address has bit 15 set, bit 14 clear and low nibble 0xB stores data bits 3:0 as the program bank, so that 0xB7FB acts like 0x800B. From the next cycle, `prg_page` for CPU addresses 0x8000–0xBFFF equals that bank.
- R3: For CPU addresses 0xC000–0xFFFF, `prg_page` always equals `prg_count` minus 1. Writes in that range change no register.
- R4: Writes with low nibble 0xC, 0xD, 0xE and 0xF (bit 15 set, bit 14 clear) store data bits 3:0 into character slots 0 to 3. Address bits 1:0 choose the slot. The slot is read out when `ppu_hi` is 0, 1, 2 or 3 (picture addresses 0x0000, 0x0800, 0x1000, 0x1800). `chr_page` is the stored number reduced modulo 2^CHR_CNT_LOG2 by keeping its low bits.
- R5: A write with low nibble 0xA sets `mir_mode` from data bits 1:0 (0 vertical, 1 horizontal, 2 single-screen lower, 3 single-screen upper). The same write sets the work-RAM enable from data bit 3.
- R6: `wram_we` is high in a cycle only when `cpu_wr` is high, the address is in 0x6000–0x7FFF and the enable is set.
- R7: Writes with bit 15 set, bit 14 clear and low nibble 0x0 to 0x9 change no register.
- R8: While `cpu_rd` is high, address 0x4800 returns 0x64 with bit 7 equal to `dip_sw` (0x64 or 0xE4). Addresses 0x5000 and 0x5800 return 0x00. In all three cases `rd_valid` is 1.
- R9: For every other address, and whenever `cpu_rd` is low, `rd_valid` is 0 and `rd_data` is 0.
- R10: During the cycle that writes a bank register, the translated outputs still show the old value. The new value appears from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_rd | input | 1 | CPU read strobe |
| dip_sw | input | 1 | Static DIP switch level |
| prg_count | input | PRG_CNT_W | Number of installed 16 KiB program banks |
| ppu_hi | input | 2 | Picture address bits 12:11 |
| prg_page | output | PRG_CNT_W | Program bank for the current CPU address |
| chr_page | output | CHR_CNT_LOG2 | Character bank for the current picture address |
| mir_mode | output | 2 | Nametable mirroring code |
| wram_we | output | 1 | Gated work-RAM write strobe |
| rd_data | output | 8 | Read data for decoded addresses |
| rd_valid | output | 1 | High when the block drives the read data |

## Verification
Two things can fall in one cycle. One is a bank register write; the other is the translation that register feeds. A write to 0x800B places a window address on the bus, and a write to a character slot happens while `ppu_hi` selects that same slot. The bench samples `prg_page` and `chr_page` before the clock edge, where it expects the old bank. It samples again after the edge, where it expects the new one. The work-RAM gate is also tested in the cycle right after a write to 0x800A that changes the enable.

// File: rtl/cart_pkg.sv
package cart_pkg;
  localparam int BANK_SEL_W = 4;
  localparam int SLOT_N     = 4;

  typedef enum logic [1:0] {
    MIR_VERT   = 2'd0,
    MIR_HORZ   = 2'd1,
    MIR_ONE_LO = 2'd2,
    MIR_ONE_HI = 2'd3
  } mir_t;

  localparam logic [3:0] OFS_CTRL = 4'hA;
  localparam logic [3:0] OFS_PRG  = 4'hB;
  localparam logic [1:0] OFS_CHR_TOP = 2'b11;

  localparam logic [15:0] ADDR_STATUS = 16'h4800;
  localparam logic [15:0] ADDR_ZERO_A = 16'h5000;
  localparam logic [15:0] ADDR_ZERO_B = 16'h5800;
  localparam logic [7:0]  STATUS_BASE = 8'h64;
endpackage

// File: rtl/cart_bank_regs.sv
module cart_bank_regs
  import cart_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic [3:0]                        offs,
  input  logic [BANK_SEL_W-1:0]             wdata,
  output logic [BANK_SEL_W-1:0]             prg_bank,
  output logic [SLOT_N-1:0][BANK_SEL_W-1:0] chr_bank,
  output mir_t                              mir,
  output logic                              wram_en
);
  logic [BANK_SEL_W-1:0]             prg_q;
  logic [SLOT_N-1:0][BANK_SEL_W-1:0] chr_q;
  mir_t                              mir_q;
  logic                              wram_en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prg_q     <= '0;
      mir_q     <= MIR_VERT;
      wram_en_q <= 1'b0;
    end else if (wr_en) begin
      if (offs == OFS_PRG) prg_q <= wdata;
      if (offs == OFS_CTRL) begin
        mir_q     <= mir_t'(wdata[1:0]);
        wram_en_q <= wdata[3];
      end
    end
  end

  for (genvar s = 0; s < SLOT_N; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) chr_q[s] <= '0;
      else if (wr_en && offs[3:2] == OFS_CHR_TOP && offs[1:0] == 2'(s))
        chr_q[s] <= wdata;
    end

    a_r4_slot_load: assert property (@(posedge clk) disable iff (rst)
      (wr_en && offs == {OFS_CHR_TOP, 2'(s)}) |=> chr_q[s] == $past(wdata));
  end

  assign prg_bank = prg_q;
  assign chr_bank = chr_q;
  assign mir      = mir_q;
  assign wram_en  = wram_en_q;

  a_r2_prg_load: assert property (@(posedge clk) disable iff (rst)
    (wr_en && offs == OFS_PRG) |=> prg_q == $past(wdata));

  a_r5_ctrl_load: assert property (@(posedge clk) disable iff (rst)
    (wr_en && offs == OFS_CTRL) |=>
      (mir_q == mir_t'($past(wdata[1:0])) && wram_en_q == $past(wdata[3])));

  a_r7_low_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && offs < OFS_CTRL) |=>
      ($stable(prg_q) && $stable(chr_q) && $stable(mir_q) && $stable(wram_en_q)));
endmodule

// File: rtl/cart_prg_map.sv
module cart_prg_map
  import cart_pkg::*;
#(
  parameter int PRG_CNT_W = 8
) (
  input  logic                  hi_window,
  input  logic [BANK_SEL_W-1:0] prg_bank,
  input  logic [PRG_CNT_W-1:0]  prg_count,
  output logic [PRG_CNT_W-1:0]  prg_page
);
  localparam int PAD_W = PRG_CNT_W - BANK_SEL_W;
  logic [PRG_CNT_W-1:0] sw_page;
  logic [PRG_CNT_W-1:0] last_page;

  if (PAD_W > 0) begin : g_pad
    assign sw_page = {{PAD_W{1'b0}}, prg_bank};
  end else begin : g_trim
    assign sw_page = prg_bank[PRG_CNT_W-1:0];
  end

  assign last_page = prg_count - 1'b1;
  assign prg_page  = hi_window ? last_page : sw_page;
endmodule

// File: rtl/cart_chr_map.sv
module cart_chr_map
  import cart_pkg::*;
#(
  parameter int CHR_CNT_LOG2 = 3
) (
  input  logic [1:0]                        slot,
  input  logic [SLOT_N-1:0][BANK_SEL_W-1:0] chr_bank,
  output logic [CHR_CNT_LOG2-1:0]           chr_page
);
  logic [BANK_SEL_W-1:0] picked;
  assign picked = chr_bank[slot];

  if (CHR_CNT_LOG2 <= BANK_SEL_W) begin : g_mask
    assign chr_page = picked[CHR_CNT_LOG2-1:0];
  end else begin : g_wide
    assign chr_page = {{(CHR_CNT_LOG2-BANK_SEL_W){1'b0}}, picked};
  end
endmodule

// File: rtl/cart_rd_mux.sv
module cart_rd_mux
  import cart_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        rd,
  input  logic [15:0] addr,
  input  logic        dip,
  output logic [7:0]  data,
  output logic        valid
);
  always_comb begin
    data  = 8'h00;
    valid = 1'b0;
    if (rd) begin
      unique case (addr)
        ADDR_STATUS: begin
          data  = {dip, STATUS_BASE[6:0]};
          valid = 1'b1;
        end
        ADDR_ZERO_A, ADDR_ZERO_B: valid = 1'b1;
        default: valid = 1'b0;
      endcase
    end
  end

  a_r9_no_drive_idle: assert property (@(posedge clk) disable iff (rst)
    !rd |-> (!valid && data == 8'h00));
endmodule

// File: rtl/cart_bank_decoder.sv
module cart_bank_decoder
  import cart_pkg::*;
#(
  parameter int PRG_CNT_W    = 8,
  parameter int CHR_CNT_LOG2 = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [15:0]             cpu_addr,
  input  logic [7:0]              cpu_wdata,
  input  logic                    cpu_wr,
  input  logic                    cpu_rd,
  input  logic                    dip_sw,
  input  logic [PRG_CNT_W-1:0]    prg_count,
  input  logic [1:0]              ppu_hi,
  output logic [PRG_CNT_W-1:0]    prg_page,
  output logic [CHR_CNT_LOG2-1:0] chr_page,
  output logic [1:0]              mir_mode,
  output logic                    wram_we,
  output logic [7:0]              rd_data,
  output logic                    rd_valid
);
  logic                              reg_wr;
  logic [BANK_SEL_W-1:0]             prg_bank;
  logic [SLOT_N-1:0][BANK_SEL_W-1:0] chr_bank;
  mir_t                              mir;
  logic                              wram_en;
  logic                              unused_hi_data;

  assign unused_hi_data = ^cpu_wdata[7:BANK_SEL_W];
  assign reg_wr = cpu_wr && (cpu_addr[15:14] == 2'b10);

  cart_bank_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (reg_wr),
    .offs     (cpu_addr[3:0]),
    .wdata    (cpu_wdata[BANK_SEL_W-1:0]),
    .prg_bank (prg_bank),
    .chr_bank (chr_bank),
    .mir      (mir),
    .wram_en  (wram_en)
  );

  cart_prg_map #(.PRG_CNT_W(PRG_CNT_W)) u_prg (
    .hi_window (cpu_addr[14]),
    .prg_bank  (prg_bank),
    .prg_count (prg_count),
    .prg_page  (prg_page)
  );

  cart_chr_map #(.CHR_CNT_LOG2(CHR_CNT_LOG2)) u_chr (
    .slot     (ppu_hi),
    .chr_bank (chr_bank),
    .chr_page (chr_page)
  );

  cart_rd_mux u_rd (
    .clk   (clk),
    .rst   (rst),
    .rd    (cpu_rd),
    .addr  (cpu_addr),
    .dip   (dip_sw),
    .data  (rd_data),
    .valid (rd_valid)
  );

  assign mir_mode = mir;
  assign wram_we  = cpu_wr && (cpu_addr[15:13] == 3'b011) && wram_en;

  a_r6_gate_needs_enable: assert property (@(posedge clk) disable iff (rst)
    wram_we |-> wram_en);

  a_r3_upper_writes_inert: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr[15:14] == 2'b11) |=> ($stable(prg_bank) && $stable(chr_bank)));
endmodule

// File: tb/cart_bank_decoder_tb_top.sv
module cart_bank_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_wdata = 8'h00;
  logic        cpu_wr = 1'b0;
  logic        cpu_rd = 1'b0;
  logic        dip_sw = 1'b0;
  logic [7:0]  prg_count = 8'd9;
  logic [1:0]  ppu_hi = 2'd0;
  logic [7:0]  prg_page;
  logic [2:0]  chr_page;
  logic [1:0]  mir_mode;
  logic        wram_we;
  logic [7:0]  rd_data;
  logic        rd_valid;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  cart_bank_decoder #(.PRG_CNT_W(8), .CHR_CNT_LOG2(3)) dut_i (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .dip_sw(dip_sw), .prg_count(prg_count),
    .ppu_hi(ppu_hi), .prg_page(prg_page), .chr_page(chr_page),
    .mir_mode(mir_mode), .wram_we(wram_we), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic prg_at(input logic [15:0] a, input string req, input int exp);
    cpu_addr = a; #1;
    chk(req, prg_page, exp);
  endtask

  task automatic chr_at(input logic [1:0] s, input string req, input int exp);
    ppu_hi = s; #1;
    chk(req, chr_page, exp);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    prg_at(16'h8000, "R1 prg", 0);
    for (int s = 0; s < 4; s++) chr_at(2'(s), "R1 chr", 0);
    chk("R1 mir", mir_mode, 0);
    cpu_addr = 16'h6000; cpu_wr = 1'b1; #1;
    chk("R1 wram blocked", wram_we, 0);
    cpu_wr = 1'b0;
  endtask

  task automatic t_prg();
    cpu_write(16'h800B, 8'h03);
    prg_at(16'h8000, "R2 bank 3", 3);
    prg_at(16'hBFFF, "R2 window top", 3);
    cpu_write(16'hB7FB, 8'h5A);
    prg_at(16'h8123, "R2 mirrored address, low nibble", 8'h0A);
  endtask

  task automatic t_fixed();
    prg_count = 8'd9;
    prg_at(16'hC000, "R3 last of 9", 8);
    cpu_write(16'hC00B, 8'h07);
    cpu_write(16'hC00C, 8'h07);
    prg_at(16'h8000, "R3 upper write inert prg", 8'h0A);
    chr_at(2'd0, "R3 upper write inert chr", 0);
    prg_count = 8'd16;
    prg_at(16'hFFFF, "R3 last of 16", 15);
    prg_count = 8'd9;
  endtask

  task automatic t_chr();
    cpu_write(16'h800C, 8'h03);
    cpu_write(16'h800D, 8'h05);
    cpu_write(16'h800E, 8'h07);
    cpu_write(16'h800F, 8'h09);
    chr_at(2'd0, "R4 slot0", 3);
    chr_at(2'd1, "R4 slot1", 5);
    chr_at(2'd2, "R4 slot2", 7);
    chr_at(2'd3, "R4 slot3 modulo 8", 1);
  endtask

  task automatic t_mirror();
    for (int m = 0; m < 4; m++) begin
      cpu_write(16'h800A, 8'(m));
      chk("R5 mirroring", mir_mode, m);
    end
  endtask

  task automatic t_wram();
    cpu_write(16'h800A, 8'h08);
    chk("R5 mirroring with enable", mir_mode, 0);
    @(negedge clk);
    cpu_wr = 1'b1;
    cpu_addr = 16'h6000; #1; chk("R6 low edge", wram_we, 1);
    cpu_addr = 16'h7FFF; #1; chk("R6 high edge", wram_we, 1);
    cpu_addr = 16'h5FFF; #1; chk("R6 below range", wram_we, 0);
    cpu_wr = 1'b0;
    cpu_addr = 16'h7000; cpu_rd = 1'b1; #1; chk("R6 read no strobe", wram_we, 0);
    cpu_rd = 1'b0;
    cpu_write(16'h800A, 8'h00);
    @(negedge clk);
    cpu_addr = 16'h7000; cpu_wr = 1'b1; #1;
    chk("R6 disabled again", wram_we, 0);
    cpu_wr = 1'b0;
  endtask

  task automatic t_ignored();
    cpu_write(16'h800A, 8'h01);
    for (int o = 0; o < 10; o++) cpu_write(16'h8000 | 16'(o), 8'hFF);
    prg_at(16'h8000, "R7 prg kept", 8'h0A);
    chr_at(2'd1, "R7 chr kept", 5);
    chk("R7 mir kept", mir_mode, 1);
    cpu_addr = 16'h7000; cpu_wr = 1'b1; #1;
    chk("R7 wram enable kept", wram_we, 0);
    cpu_wr = 1'b0;
  endtask

  task automatic rd_at(input logic [15:0] a, input string req, input int ed, input int ev);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1; #1;
    chk({req, " data"}, rd_data, ed);
    chk({req, " valid"}, rd_valid, ev);
    cpu_rd = 1'b0;
  endtask

  task automatic t_reads();
    dip_sw = 1'b0;
    rd_at(16'h4800, "R8 status dip off", 8'h64, 1);
    dip_sw = 1'b1;
    rd_at(16'h4800, "R8 status dip on", 8'hE4, 1);
    rd_at(16'h5000, "R8 zero A", 0, 1);
    rd_at(16'h5800, "R8 zero B", 0, 1);
    rd_at(16'h4801, "R9 neighbour", 0, 0);
    rd_at(16'h8000, "R9 rom area", 0, 0);
    @(negedge clk);
    cpu_addr = 16'h4800; cpu_rd = 1'b0; #1;
    chk("R9 no strobe valid", rd_valid, 0);
    chk("R9 no strobe data", rd_data, 0);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    cpu_addr = 16'h800B; cpu_wdata = 8'h06; cpu_wr = 1'b1; #1;
    chk("R10 prg old during write", prg_page, 8'h0A);
    @(negedge clk);
    cpu_wr = 1'b0; #1;
    chk("R10 prg new after edge", prg_page, 6);
    @(negedge clk);
    ppu_hi = 2'd2; cpu_addr = 16'h800E; cpu_wdata = 8'h04; cpu_wr = 1'b1; #1;
    chk("R10 chr old during write", chr_page, 7);
    @(negedge clk);
    cpu_wr = 1'b0; #1;
    chk("R10 chr new after edge", chr_page, 4);
  endtask

  initial begin
    t_reset();
    t_prg();
    t_fixed();
    t_chr();
    t_mirror();
    t_wram();
    t_ignored();
    t_reads();
    t_same_cycle();
    t_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule